// File: doc/BRIEF.md
# Multi-Level DMA Channel Arbiter

This block picks one winner among up to sixteen DMA channel requests. Each channel carries a priority level. The highest level that has a pending request always wins. Among the channels of that level, the winner comes from the level's own scheduling mode: static or round-robin. One enable bit per level selects the mode.

Each level has a 4-bit priority-number field, and that field does two jobs. In round-robin mode it holds the last channel granted at the level, and the next search starts just after it. In static mode it names the channel that ranks first, and the ranking wraps around from there. Changing the mode leaves the field as it is. After round-robin is switched off, the last granted channel therefore becomes the origin of the static order.

The grant is registered and stays stable until the holder releases it. The next arbitration takes place on the cycle of the release, or on any cycle in which no grant is active. A single 32-bit configuration word holds the enable bits and the priority fields. It can be written at any time and is always readable.

Top module: `dma_lvl_arbiter`

## Requirements
- R1: While reset is low, and on the first cycle after it, no grant is asserted and the configuration word reads zero. Reset is synchronous and active-low.
- R2: Configuration word layout. Level L keeps its priority number in bits [8L+3:8L] and its round-robin enable in bit 8L+7. With three levels every other bit reads zero and ignores writes, so writing all ones reads back 32'h008F8F8F. A write takes effect at the clock edge.
- R3: Each channel c has a level code in `ch_lvl_i[2c+1:2c]`, and a larger code means higher priority. A new grant always goes to a requesting channel at the highest level with a request. A channel whose code is NUM_LVL or more is never granted.
- R4: In static mode with priority number x, the order is x, x+1, …, NUM_CH-1, then 0, …, x-1. With x = 0 the lowest requesting index wins.
- R5: In round-robin mode the search starts at the priority number plus one and wraps modulo NUM_CH. The level's priority number is then updated to the granted index.
- R6: Static grants leave the priority number unchanged. Turning round-robin off does not clear the field, so the last granted index becomes the static origin.
- R7: Arbitration happens only when no grant is active or when `gnt_done_i` is high. The grant appears one cycle later. While it is held, it stays stable whatever the requests do. When arbitration finds no eligible request, the grant drops.
- R8: If a configuration write and a round-robin update hit the same cycle, the written value is kept. The arbitration in that cycle uses the values from before the write.
- R9: `gnt_o` is one-hot with its set bit at `gnt_idx_o` whenever `gnt_valid_o` is high, and it is all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_CH | Per-channel request |
| ch_lvl_i | input | NUM_CH*LVL_W | Per-channel level code, channel c in bits [LVL_W*c +: LVL_W] |
| gnt_done_i | input | 1 | Current holder releases the grant |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Current configuration word |
| gnt_o | output | NUM_CH | One-hot grant |
| gnt_valid_o | output | 1 | A grant is active |
| gnt_idx_o | output | IDX_W | Index of the granted channel |

## Verification
The bench targets wrap-around in both modes:
- **Static origin near the top.** A design that ranks from channel 0 would pick a lower channel where the rotated order picks a higher one.
- **Round-robin pointer wrapping past the last channel.** A design that does not wrap would give no grant or the wrong channel.

It then checks the field kept across a mode change, where a design that clears it would restart the static order at channel 0.

A back-to-back release sequence shows whether the round-robin pointer really advances.

A same-cycle write and update checks two things. If the update wins, the following grant goes to the wrong channel. If the arbitration in that cycle sees the new value, that cycle's own grant goes to the wrong channel.

Finally, a grant held while higher-level requests arrive would expose a design that preempts its holder.

// File: rtl/dma_arb_pkg.sv
// Package dma_arb_pkg
// Shared constants and helpers for the configuration word layout of the
// multi-level DMA arbiter. Assumes at most four levels, each with an
// 8-bit slot in a 32-bit word.
package dma_arb_pkg;

    localparam int REG_W      = 32;
    localparam int FIELD_W    = 4;
    localparam int LVL_STRIDE = 8;
    localparam int EN_OFS     = 7;
    localparam int MAX_LVL    = REG_W / LVL_STRIDE;

    // Low bit of the priority-number field of a level
    function automatic int field_lsb(input int lvl);
        return lvl * LVL_STRIDE;
    endfunction

    // Bit position of the round-robin enable of a level
    function automatic int en_pos(input int lvl);
        return lvl * LVL_STRIDE + EN_OFS;
    endfunction

    // Mask of implemented bits for a given level count
    function automatic logic [REG_W-1:0] live_mask(input int n_lvl);
        logic [REG_W-1:0] m;
        m = '0;
        for (int l = 0; l < n_lvl; l++) begin
            m[field_lsb(l) +: FIELD_W] = '1;
            m[en_pos(l)]               = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dma_arb_cfg.sv
// Module dma_arb_cfg
// Holds the per-level round-robin enables and priority numbers. A software
// write replaces all levels at once. A round-robin grant update rewrites
// one level's priority number, unless a software write lands in the same
// cycle, in which case the write wins. Assumes NUM_LVL <= MAX_LVL and
// IDX_W <= FIELD_W.
module dma_arb_cfg
    import dma_arb_pkg::*;
#(
    parameter int NUM_LVL = 3,
    parameter int IDX_W   = 4,
    parameter int LVL_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [REG_W-1:0]           wr_data,
    input  logic                       upd_vld,
    input  logic [LVL_W-1:0]           upd_lvl,
    input  logic [IDX_W-1:0]           upd_idx,
    output logic [NUM_LVL-1:0]         rr_en,
    output logic [NUM_LVL*FIELD_W-1:0] prio_num,
    output logic [REG_W-1:0]           rd_data
);

    localparam logic [REG_W-1:0] LIVE = live_mask(NUM_LVL);

    logic [NUM_LVL-1:0]              en_q;
    logic [NUM_LVL-1:0][FIELD_W-1:0] num_q;
    logic                            unused_rsv;

    // Reserved write bits are consumed here only to mark them as intentionally dropped
    assign unused_rsv = ^(wr_data & ~LIVE);

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        // Per-level state: software write first, then round-robin update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[l]  <= 1'b0;
                num_q[l] <= '0;
            end else if (wr_en) begin
                en_q[l]  <= wr_data[en_pos(l)];
                num_q[l] <= wr_data[field_lsb(l) +: FIELD_W];
            end else if (upd_vld && (upd_lvl == LVL_W'(l))) begin
                num_q[l] <= FIELD_W'(upd_idx);
            end
        end
        assign rr_en[l]                        = en_q[l];
        assign prio_num[l*FIELD_W +: FIELD_W]  = num_q[l];
    end

    // Assemble the read-back word; unimplemented bits stay zero
    always_comb begin
        rd_data = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            rd_data[field_lsb(l) +: FIELD_W] = num_q[l];
            rd_data[en_pos(l)]               = en_q[l];
        end
    end

endmodule

// File: rtl/dma_arb_rot_pick.sv
// Module dma_arb_rot_pick
// Finds the first set bit of a request vector when the search starts at a
// given origin and wraps modulo NUM_CH. The origin may be NUM_CH or larger
// and is reduced first. Purely combinational.
module dma_arb_rot_pick #(
    parameter int NUM_CH = 16,
    parameter int ORG_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [ORG_W-1:0]  origin,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    // Rotating first-one search from the reduced origin
    always_comb begin
        int unsigned start;
        int unsigned c;
        hit   = 1'b0;
        idx   = '0;
        start = int'(origin) % NUM_CH;
        for (int k = 0; k < NUM_CH; k++) begin
            c = (start + k) % NUM_CH;
            if (!hit && req[c]) begin
                hit = 1'b1;
                idx = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/dma_arb_lvl_sel.sv
// Module dma_arb_lvl_sel
// Splits the request vector into one vector per level from the per-channel
// level codes, and reports the highest level with a pending request.
// Channels whose code is not below NUM_LVL land in no level.
module dma_arb_lvl_sel #(
    parameter int NUM_CH  = 16,
    parameter int NUM_LVL = 3,
    parameter int LVL_W   = 2
) (
    input  logic [NUM_CH-1:0]              req,
    input  logic [NUM_CH*LVL_W-1:0]        ch_lvl,
    output logic [NUM_LVL-1:0][NUM_CH-1:0] lvl_req,
    output logic [LVL_W-1:0]               top_lvl,
    output logic                           any_req
);

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign lvl_req[l][c] = req[c] && (ch_lvl[c*LVL_W +: LVL_W] == LVL_W'(l));
        end
    end

    // Scan upward so the highest pending level is the one kept
    always_comb begin
        top_lvl = '0;
        any_req = 1'b0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (|lvl_req[l]) begin
                top_lvl = LVL_W'(l);
                any_req = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_lvl_arbiter.sv
// Module dma_lvl_arbiter
// Top of the multi-level DMA channel arbiter. One rotating picker per level
// runs in parallel, and its origin is the level's priority number (static)
// or that number plus one (round-robin). The highest pending level supplies
// the winner. The grant is registered and is re-evaluated only when idle or
// released. Assumes 2 <= NUM_CH <= 16 and 1 <= NUM_LVL <= 4.
module dma_lvl_arbiter
    import dma_arb_pkg::*;
#(
    parameter int  NUM_CH  = 16,
    parameter int  NUM_LVL = 3,
    localparam int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int IDX_W   = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       req_i,
    input  logic [NUM_CH*LVL_W-1:0] ch_lvl_i,
    input  logic                    gnt_done_i,
    input  logic                    cfg_we_i,
    input  logic [31:0]             cfg_wdata_i,
    output logic [31:0]             cfg_rdata_o,
    output logic [NUM_CH-1:0]       gnt_o,
    output logic                    gnt_valid_o,
    output logic [IDX_W-1:0]        gnt_idx_o
);

    localparam int ORG_W = FIELD_W + 1;

    logic [NUM_LVL-1:0]              rr_en;
    logic [NUM_LVL*FIELD_W-1:0]      prio_num;
    logic [NUM_LVL-1:0][NUM_CH-1:0]  lvl_req;
    logic [LVL_W-1:0]                top_lvl;
    logic                            any_req;
    logic [NUM_LVL-1:0]              pick_hit;
    logic [NUM_LVL-1:0][IDX_W-1:0]   pick_idx;
    logic [IDX_W-1:0]                win_idx;
    logic                            win_rr;
    logic                            arb_now;
    logic                            gnt_valid_q;
    logic [IDX_W-1:0]                gnt_idx_q;

    dma_arb_cfg #(
        .NUM_LVL (NUM_LVL),
        .IDX_W   (IDX_W),
        .LVL_W   (LVL_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we_i),
        .wr_data  (cfg_wdata_i),
        .upd_vld  (arb_now && any_req && win_rr),
        .upd_lvl  (top_lvl),
        .upd_idx  (win_idx),
        .rr_en    (rr_en),
        .prio_num (prio_num),
        .rd_data  (cfg_rdata_o)
    );

    dma_arb_lvl_sel #(
        .NUM_CH  (NUM_CH),
        .NUM_LVL (NUM_LVL),
        .LVL_W   (LVL_W)
    ) u_sel (
        .req     (req_i),
        .ch_lvl  (ch_lvl_i),
        .lvl_req (lvl_req),
        .top_lvl (top_lvl),
        .any_req (any_req)
    );

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_pick
        logic [ORG_W-1:0] origin;
        // Round-robin starts after the last grant; static starts at the field
        assign origin = rr_en[l] ? ({1'b0, prio_num[l*FIELD_W +: FIELD_W]} + ORG_W'(1))
                                 :  {1'b0, prio_num[l*FIELD_W +: FIELD_W]};
        dma_arb_rot_pick #(
            .NUM_CH (NUM_CH),
            .ORG_W  (ORG_W),
            .IDX_W  (IDX_W)
        ) u_pick (
            .req    (lvl_req[l]),
            .origin (origin),
            .hit    (pick_hit[l]),
            .idx    (pick_idx[l])
        );
    end

    // Select the winning level's pick and its mode
    always_comb begin
        win_idx = '0;
        win_rr  = 1'b0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (top_lvl == LVL_W'(l) && pick_hit[l]) begin
                win_idx = pick_idx[l];
                win_rr  = rr_en[l];
            end
        end
    end

    assign arb_now = !gnt_valid_q || gnt_done_i;

    // Grant register: re-arbitrate when idle or released, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid_q <= 1'b0;
            gnt_idx_q   <= '0;
        end else if (arb_now) begin
            gnt_valid_q <= any_req;
            gnt_idx_q   <= any_req ? win_idx : '0;
        end
    end

    // One-hot decode of the held grant
    always_comb begin
        gnt_o = '0;
        if (gnt_valid_q) gnt_o[gnt_idx_q] = 1'b1;
    end

    assign gnt_valid_o = gnt_valid_q;
    assign gnt_idx_o   = gnt_idx_q;

endmodule

// File: rtl/dma_arb_chk.sv
// Module dma_arb_chk
// Assertion checker bound to dma_lvl_arbiter. It keeps its own one-cycle
// copies of the inputs and then relates each new grant to the requests,
// levels and configuration seen in the cycle that produced it.
module dma_arb_chk
    import dma_arb_pkg::*;
#(
    parameter int  NUM_CH  = 16,
    parameter int  NUM_LVL = 3,
    localparam int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int IDX_W   = $clog2(NUM_CH)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       req_i,
    input logic [NUM_CH*LVL_W-1:0] ch_lvl_i,
    input logic                    gnt_done_i,
    input logic                    cfg_we_i,
    input logic [31:0]             cfg_rdata_o,
    input logic [NUM_CH-1:0]       gnt_o,
    input logic                    gnt_valid_o,
    input logic [IDX_W-1:0]        gnt_idx_o
);

    logic [NUM_CH-1:0]       req_q;
    logic [NUM_CH*LVL_W-1:0] lvl_q;
    logic                    arb_q;
    logic                    we_q;
    logic [NUM_LVL-1:0]      en_q;
    logic [LVL_W-1:0]        top_q;
    logic                    any_q;
    logic [LVL_W-1:0]        g_lvl;
    logic                    new_gnt;

    // Capture what the arbiter saw in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            lvl_q <= '0;
            arb_q <= 1'b0;
            we_q  <= 1'b0;
            en_q  <= '0;
        end else begin
            req_q <= req_i;
            lvl_q <= ch_lvl_i;
            arb_q <= !gnt_valid_o || gnt_done_i;
            we_q  <= cfg_we_i;
            for (int l = 0; l < NUM_LVL; l++) en_q[l] <= cfg_rdata_o[en_pos(l)];
        end
    end

    // Highest eligible level among last cycle's requests
    always_comb begin
        logic [LVL_W-1:0] lv;
        top_q = '0;
        any_q = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            lv = lvl_q[c*LVL_W +: LVL_W];
            if (req_q[c] && int'(lv) < NUM_LVL) begin
                any_q = 1'b1;
                if (lv > top_q) top_q = lv;
            end
        end
    end

    assign g_lvl   = lvl_q[int'(gnt_idx_o)*LVL_W +: LVL_W];
    assign new_gnt = arb_q && gnt_valid_o;

    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!gnt_valid_o && gnt_o == '0 && cfg_rdata_o == '0));

    assert_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        new_gnt |-> (req_q[gnt_idx_o] && g_lvl == top_q));

    assert_rrptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (new_gnt && en_q[g_lvl] && !we_q) |->
            (cfg_rdata_o[int'(g_lvl)*LVL_STRIDE +: FIELD_W] == FIELD_W'(gnt_idx_o)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && !gnt_done_i) |=> (gnt_valid_o && $stable(gnt_idx_o)));

    assert_arb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arb_q |-> (gnt_valid_o == any_q));

    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o) && (!gnt_valid_o || gnt_o[gnt_idx_o]) && (gnt_valid_o || gnt_o == '0));

endmodule

bind dma_lvl_arbiter dma_arb_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_LVL (NUM_LVL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .ch_lvl_i    (ch_lvl_i),
    .gnt_done_i  (gnt_done_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_rdata_o (cfg_rdata_o),
    .gnt_o       (gnt_o),
    .gnt_valid_o (gnt_valid_o),
    .gnt_idx_o   (gnt_idx_o)
);

// File: tb/sim_dma_lvl_arbiter.sv
// Bench for dma_lvl_arbiter.
// Channels 0-5 sit at level 0, 6-11 at level 1 and 12-15 at level 2.
module sim_dma_lvl_arbiter;

    localparam int NCH = 16;
    localparam int NLV = 3;

    typedef struct packed {
        logic        we;
        logic [31:0] wd;
        logic [15:0] rq;
        logic [3:0]  ex;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 32'h0000_0000, 16'h0006, 4'd1},   // R4 lowest index
        '{1'b0, 32'h0,         16'h1041, 4'd12},  // R3 level 2 wins
        '{1'b0, 32'h0,         16'h0041, 4'd6},   // R3 level 1 wins
        '{1'b1, 32'h0000_0003, 16'h0026, 4'd5},   // R4 origin 3
        '{1'b0, 32'h0,         16'h0007, 4'd0},   // R4 wrap to 0
        '{1'b1, 32'h0000_8003, 16'h0840, 4'd6},   // R5 rr lvl1
        '{1'b0, 32'h0,         16'h0840, 4'd11},  // R5 advance
        '{1'b0, 32'h0,         16'h0840, 4'd6},   // R5 wrap
        '{1'b0, 32'h0,         16'h0880, 4'd7},   // R5 next after 6
        '{1'b1, 32'h0000_0703, 16'h0840, 4'd11},  // R6 kept field as origin
        '{1'b0, 32'h0,         16'h0840, 4'd11},  // R6 static no update
        '{1'b1, 32'h0080_0703, 16'h3000, 4'd12},  // R5 rr lvl2
        '{1'b0, 32'h0,         16'hF000, 4'd13},  // R5 advance
        '{1'b0, 32'h0,         16'h1000, 4'd12}   // R5 wrap
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    req_i = '0;
    logic [NCH*2-1:0]  ch_lvl_i;
    logic              gnt_done_i = 1'b0;
    logic              cfg_we_i = 1'b0;
    logic [31:0]       cfg_wdata_i = '0;
    logic [31:0]       cfg_rdata_o;
    logic [NCH-1:0]    gnt_o;
    logic              gnt_valid_o;
    logic [3:0]        gnt_idx_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_lvl_arbiter #(.NUM_CH(NCH), .NUM_LVL(NLV)) u0 (
        .clk (clk), .rst_n (rst_n), .req_i (req_i), .ch_lvl_i (ch_lvl_i),
        .gnt_done_i (gnt_done_i), .cfg_we_i (cfg_we_i), .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o), .gnt_o (gnt_o), .gnt_valid_o (gnt_valid_o),
        .gnt_idx_o (gnt_idx_o)
    );

    function automatic logic [NCH*2-1:0] base_map();
        logic [NCH*2-1:0] m;
        for (int c = 0; c < NCH; c++) m[c*2 +: 2] = (c < 6) ? 2'd0 : (c < 12) ? 2'd1 : 2'd2;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_gnt(input string tag, input int ch);
        chk({tag, " valid"}, 32'(gnt_valid_o), 32'd1);
        chk({tag, " idx"}, 32'(gnt_idx_o), 32'(ch));
        chk({tag, " onehot R9"}, 32'(gnt_o), 32'(1) << ch);
    endtask

    task automatic wr(input logic [31:0] v);
        cfg_we_i = 1'b1; cfg_wdata_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic rel();
        req_i = '0; gnt_done_i = 1'b1;
        @(negedge clk);
        gnt_done_i = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        ch_lvl_i = base_map();
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(gnt_valid_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant after reset", 32'(gnt_o), 32'd0);
        chk("R1 cfg after reset", cfg_rdata_o, 32'd0);

        // R2 reserved bits
        wr(32'hFFFF_FFFF);
        chk("R2 readback", cfg_rdata_o, 32'h008F_8F8F);
        wr(32'h0);
        chk("R2 cleared", cfg_rdata_o, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].we) wr(VECS[i].wd);
            req_i = VECS[i].rq;
            @(negedge clk);
            chk_gnt($sformatf("vec%0d", i), int'(VECS[i].ex));
            rel();
            chk($sformatf("vec%0d R7 drop", i), 32'(gnt_valid_o), 32'd0);
        end
        chk("R5 R6 fields after table", cfg_rdata_o, 32'h008C_0703);

        // R7 hold against higher-level requests
        wr(32'h0);
        req_i = 16'h0006;
        @(negedge clk);
        chk_gnt("R7 first", 1);
        req_i = 16'h1001;
        repeat (3) begin
            @(negedge clk);
            chk_gnt("R7 held", 1);
        end
        gnt_done_i = 1'b1;
        @(negedge clk);
        chk_gnt("R7 release rearb", 12);
        rel();

        // R5 back-to-back round-robin with continuous release
        wr(32'h0000_0080);
        req_i = 16'h0021;
        @(negedge clk);
        chk_gnt("R5 b2b a", 5);
        gnt_done_i = 1'b1;
        @(negedge clk);
        chk_gnt("R5 b2b wrap", 0);
        @(negedge clk);
        chk_gnt("R5 b2b c", 5);
        rel();

        // R8 collision: field0 now 5, write field 2 while arbitrating
        cfg_we_i = 1'b1; cfg_wdata_i = 32'h0000_0082; req_i = 16'h0021;
        @(negedge clk);
        cfg_we_i = 1'b0;
        chk_gnt("R8 uses old origin", 0);
        chk("R8 write wins", cfg_rdata_o, 32'h0000_0082);
        rel();
        req_i = 16'h000C;
        @(negedge clk);
        chk_gnt("R8 next from written origin", 3);
        rel();

        // R3 out-of-range level code ignored
        wr(32'h0);
        ch_lvl_i[7:6] = 2'd3;
        req_i = 16'h0008;
        @(negedge clk);
        chk("R3 bad level no grant", 32'(gnt_valid_o), 32'd0);
        req_i = 16'h0018;
        @(negedge clk);
        chk_gnt("R3 bad level skipped", 4);
        rel();
        ch_lvl_i = base_map();

        summary();
    end

endmodule